// File: doc/BRIEF.md
# Character-raster timing generator

This block produces the horizontal and vertical timing for a display that is drawn in character cells. It runs on one clock and advances only in cycles where a character-time enable is high. Inside each line it counts character times, and inside each frame it counts lines. From these two positions it produces horizontal and vertical sync, horizontal and vertical blanking, and a display-enable strobe. It also presents a status byte that a host can sample to see the retrace state.

The lengths of all intervals come from an eight-byte parameter set. The host writes this set one byte at a time. Writes go into a holding copy, and the working copy is replaced only at the end of a frame, so a frame in progress keeps one consistent geometry. The set packs its fields across byte boundaries:

- Horizontal timing includes a fixed overhead of three character times.
- A line-count field of zero stands for 1024 lines.
- When every vertical blanking field is zero, one blanking line is inserted instead.

Two command strobes, start and stop, control whether display enable can be asserted.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the working and holding sets both hold bytes 0..7 = 10h, 4Eh, 07h, 25h, 07h, 07h, 90h, 65h. This gives 80 active characters, a 106-character line, 400 active lines and a 440-line frame. All outputs except display enable are low, display enable is high, and status reads 80h.
- R2: The active width is byte 1 plus 2. With character position p counted from 0 at the start of the line, hblank is high exactly when p is at least the active width.
- R3: Each line runs in this order: active, front porch, sync, then back porch plus a fixed 3. The front porch is byte 4 bits 5:0. Let word H be byte 3 in bits 15:8 and byte 2 in bits 7:0; the sync width is H bits 4:0 and the back porch is H bits 15:10. hsync is high only during the sync interval.
- R4: Let word V be byte 7 in bits 15:8 and byte 6 in bits 7:0. The active line count is V bits 9:0, where 0 means 1024. vblank is high exactly when the line position is at least that count.
- R5: After the active lines come the front porch (byte 5 bits 5:0), then sync (H bits 9:5), then back porch (V bits 15:10). vsync is high only during the sync lines. When all three of these fields are zero, the frame has one blanking line and no vsync.
- R6: A byte write (wr_addr selects the byte) changes only the holding set. The working set takes the whole holding set on the enabled cycle that ends the last line of a frame. A write in that same cycle counts toward the following frame.
- R7: Positions and all sync and blank outputs change only in cycles where char_en is high.
- R8: The status byte is {1, hblank, vsync, 00000b}: bit 7 is always 1, bit 6 is horizontal retrace and bit 5 is vertical sync.
- R9: cmd_stop clears the run state and cmd_start sets it, each on the next clock. If both are given in the same cycle, stop wins.
- R10: disp_en is high exactly when the run state is set and neither hblank nor vblank is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_en | input | 1 | One character time elapses in this cycle |
| wr_en | input | 1 | Write one parameter byte into the holding set |
| wr_addr | input | 3 | Byte index in the parameter set |
| wr_data | input | 8 | Byte value to write |
| cmd_start | input | 1 | Set the run state |
| cmd_stop | input | 1 | Clear the run state (has priority) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Display enable |
| status | output | 8 | Retrace status byte |

## Verification
A reference model in the bench predicts every output in every cycle, and the block is compared against it under four geometries:

- The reset geometry runs with a gappy enable. This shows that the counters follow char_en and not the clock, and that bytes written in mid-frame do not take effect early.
- A small geometry, with porch, sync and back-porch widths that all differ, separates the order of the intervals and catches a field taken from the wrong bits.
- A set whose vertical blanking fields are all zero tests the one-line substitute.
- A set whose line-count field is zero, on a six-character line, tests the 1024-line meaning.

Start and stop pulses, including both in the same cycle, are mixed into the small-geometry frames.

// File: rtl/raster_timing_pkg.sv
`timescale 1ns/1ps
package raster_timing_pkg;

   localparam int PSET_BYTES   = 8;
   localparam int PSET_AW      = $clog2(PSET_BYTES);
   localparam int H_FIXED_TAIL = 3;
   localparam int V_ZERO_LINES = 1024;

   typedef logic [PSET_BYTES*8-1:0] pset_t;

   // byte i sits at bits [8*i +: 8]
   localparam pset_t PSET_RESET = {8'h65, 8'h90, 8'h07, 8'h07,
                                   8'h25, 8'h07, 8'h4E, 8'h10};

   typedef struct packed {
      logic [15:0] h_act;
      logic [15:0] h_fp;
      logic [15:0] h_sy;
      logic [15:0] h_bp;
      logic [15:0] v_act;
      logic [15:0] v_fp;
      logic [15:0] v_sy;
      logic [15:0] v_bp;
   } tspec_t;

   function automatic tspec_t unpack_pset(input pset_t p);
      tspec_t      s;
      logic [15:0] hw;
      logic [15:0] vw;
      hw      = p[31:16];
      vw      = p[63:48];
      s.h_act = 16'(p[15:8]) + 16'd2;
      s.h_fp  = 16'(p[37:32]);
      s.h_sy  = 16'(hw[4:0]);
      s.h_bp  = 16'(hw[15:10]) + 16'(H_FIXED_TAIL);
      s.v_act = (vw[9:0] == 10'd0) ? 16'(V_ZERO_LINES) : 16'(vw[9:0]);
      s.v_sy  = 16'(hw[9:5]);
      s.v_fp  = 16'(p[45:40]);
      s.v_bp  = 16'(vw[15:10]);
      if ((s.v_sy + s.v_fp + s.v_bp) == 16'd0) s.v_fp = 16'd1;
      return s;
   endfunction

endpackage

// File: rtl/raster_param_store.sv
`timescale 1ns/1ps
module raster_param_store #(
   parameter int                 NBYTES = 8,
   parameter logic [NBYTES*8-1:0] INIT  = '0,
   localparam int                AW     = $clog2(NBYTES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                commit,
   output logic [NBYTES*8-1:0] active
);

   if (NBYTES < 2 || (1 << AW) != NBYTES) begin : g_bad_nbytes
      $error("raster_param_store: NBYTES must be a power of two");
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [7:0] hold_q;
      logic [7:0] work_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= INIT[8*i +: 8];
            work_q <= INIT[8*i +: 8];
         end else begin
            if (commit) work_q <= hold_q;
            if (wr_en && wr_addr == AW'(i)) hold_q <= wr_data;
         end
      end

      assign active[8*i +: 8] = work_q;
   end

endmodule

// File: rtl/raster_axis.sv
`timescale 1ns/1ps
module raster_axis #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] act_len,
   input  logic [W-1:0] fp_len,
   input  logic [W-1:0] sy_len,
   input  logic [W-1:0] bp_len,
   output logic         at_last,
   output logic         blank_q,
   output logic         sync_q
);

   if (W < 2) begin : g_bad_w
      $error("raster_axis: W too small");
   end

   logic [W-1:0] pos_q;
   logic [W-1:0] pos_nxt;
   logic [W-1:0] total;
   logic [W-1:0] sync_lo;
   logic [W-1:0] sync_hi;

   always_comb begin
      total   = act_len + fp_len + sy_len + bp_len;
      sync_lo = act_len + fp_len;
      sync_hi = sync_lo + sy_len;
      at_last = (pos_q == total - W'(1));
      pos_nxt = at_last ? '0 : pos_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         blank_q <= 1'b0;
         sync_q  <= 1'b0;
      end else if (step) begin
         pos_q   <= pos_nxt;
         blank_q <= (pos_nxt >= act_len);
         sync_q  <= (pos_nxt >= sync_lo) && (pos_nxt < sync_hi);
      end
   end

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen #(
   parameter int  H_W = 9,
   parameter int  V_W = 11,
   localparam int AW  = raster_timing_pkg::PSET_AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_en,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          cmd_start,
   input  logic          cmd_stop,
   output logic          hsync,
   output logic          vsync,
   output logic          hblank,
   output logic          vblank,
   output logic          disp_en,
   output logic [7:0]    status
);
   import raster_timing_pkg::*;

   // widest line 257+63+31+63+3 = 417, tallest frame 1024+63+31+63 = 1181
   if (H_W < 9 || H_W > 16) begin : g_bad_hw
      $error("raster_timing_gen: H_W must lie in 9..16");
   end
   if (V_W < 11 || V_W > 16) begin : g_bad_vw
      $error("raster_timing_gen: V_W must lie in 11..16");
   end

   pset_t  pset;
   tspec_t spec;
   logic   h_last;
   logic   v_last;
   logic   frame_end;
   logic   run_q;
   logic   unused_spec;

   assign frame_end   = char_en && h_last && v_last;
   assign spec        = unpack_pset(pset);
   assign unused_spec = ^spec;

   raster_param_store #(
      .NBYTES (PSET_BYTES),
      .INIT   (PSET_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .commit  (frame_end),
      .active  (pset)
   );

   raster_axis #(.W(H_W)) u_haxis (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (char_en),
      .act_len (spec.h_act[H_W-1:0]),
      .fp_len  (spec.h_fp[H_W-1:0]),
      .sy_len  (spec.h_sy[H_W-1:0]),
      .bp_len  (spec.h_bp[H_W-1:0]),
      .at_last (h_last),
      .blank_q (hblank),
      .sync_q  (hsync)
   );

   raster_axis #(.W(V_W)) u_vaxis (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (char_en && h_last),
      .act_len (spec.v_act[V_W-1:0]),
      .fp_len  (spec.v_fp[V_W-1:0]),
      .sy_len  (spec.v_sy[V_W-1:0]),
      .bp_len  (spec.v_bp[V_W-1:0]),
      .at_last (v_last),
      .blank_q (vblank),
      .sync_q  (vsync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= 1'b1;
      else if (cmd_stop)  run_q <= 1'b0;
      else if (cmd_start) run_q <= 1'b1;
   end

   assign disp_en = run_q && !hblank && !vblank;
   assign status  = {1'b1, hblank, vsync, 5'b00000};

endmodule

// File: rtl/raster_timing_chk.sv
`timescale 1ns/1ps
module raster_timing_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       char_en,
   input logic       cmd_stop,
   input logic       hsync,
   input logic       vsync,
   input logic       hblank,
   input logic       vblank,
   input logic       disp_en,
   input logic [7:0] status
);

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !char_en |=> $stable({hsync, vsync, hblank, vblank}));

   assert_hsync_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> hblank);

   assert_vsync_in_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> vblank);

   assert_status_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] && (status[6] == hblank) && (status[5] == vsync) && (status[4:0] == 5'd0));

   assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> !disp_en);

   assert_enable_in_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |-> (!hblank && !vblank));

endmodule

bind raster_timing_gen raster_timing_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .char_en  (char_en),
   .cmd_stop (cmd_stop),
   .hsync    (hsync),
   .vsync    (vsync),
   .hblank   (hblank),
   .vblank   (vblank),
   .disp_en  (disp_en),
   .status   (status)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       cmd_start = 1'b0;
   logic       cmd_stop = 1'b0;
   logic       hsync, vsync, hblank, vblank, disp_en;
   logic [7:0] status;

   always #2.5 clk = ~clk;

   raster_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .char_en(char_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .cmd_start(cmd_start),
      .cmd_stop(cmd_stop), .hsync(hsync), .vsync(vsync), .hblank(hblank),
      .vblank(vblank), .disp_en(disp_en), .status(status)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   int    en_mode = 0;
   string tag = "R1";

   localparam logic [7:0] RST_SET [8] = '{8'h10, 8'h4E, 8'h07, 8'h25,
                                          8'h07, 8'h07, 8'h90, 8'h65};

   // ---------------- reference model (from the requirements) ----------------
   typedef struct {
      bit         hs, vs, hb, vb, de;
      logic [7:0] st;
   } exp_t;

   exp_t       exp_q[$];
   logic [7:0] m_hold [8];
   logic [7:0] m_work [8];
   int         hc = 0, vc = 0, frames = 0;
   bit         run = 1'b1;

   function automatic void geom(output int ha, output int hf, output int hs,
                                output int hb, output int va, output int vf,
                                output int vs, output int vb);
      logic [15:0] wh, wv;
      wh = {m_work[3], m_work[2]};
      wv = {m_work[7], m_work[6]};
      ha = int'(m_work[1]) + 2;
      hf = int'(m_work[4][5:0]);
      hs = int'(wh[4:0]);
      hb = int'(wh[15:10]) + 3;
      va = (wv[9:0] == 10'd0) ? 1024 : int'(wv[9:0]);
      vf = int'(m_work[5][5:0]);
      vs = int'(wh[9:5]);
      vb = int'(wv[15:10]);
      if (vf + vs + vb == 0) vf = 1;
   endfunction

   always @(posedge clk) begin
      exp_t e;
      int   ha, hf, hs, hb, va, vf, vs, vb;
      bit   hl, vl;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_hold[i] = RST_SET[i];
            m_work[i] = RST_SET[i];
         end
         hc  = 0;
         vc  = 0;
         run = 1'b1;
      end else begin
         if (cmd_stop)       run = 1'b0;
         else if (cmd_start) run = 1'b1;
         if (char_en) begin
            geom(ha, hf, hs, hb, va, vf, vs, vb);
            hl = (hc == ha + hf + hs + hb - 1);
            vl = (vc == va + vf + vs + vb - 1);
            if (hl && vl) begin
               for (int i = 0; i < 8; i++) m_work[i] = m_hold[i];
               frames++;
            end
            if (hl) vc = vl ? 0 : vc + 1;
            hc = hl ? 0 : hc + 1;
         end
         if (wr_en) m_hold[wr_addr] = wr_data;
      end
      geom(ha, hf, hs, hb, va, vf, vs, vb);
      e.hb = (hc >= ha);
      e.hs = (hc >= ha + hf) && (hc < ha + hf + hs);
      e.vb = (vc >= va);
      e.vs = (vc >= va + vf) && (vc < va + vf + vs);
      e.de = run && !e.hb && !e.vb;
      e.st = {1'b1, e.hb, e.vs, 5'b00000};
      exp_q.push_back(e);
   end

   // ---------------- monitor ----------------
   task automatic cmp(input string req, input string what,
                      input logic [7:0] got, input logic [7:0] want);
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s %s (phase %s, t=%0t): got %0h expected %0h",
                  req, what, tag, $time, got, want);
      end
   endtask

   initial forever begin
      exp_t e;
      @(negedge clk);
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         n_cmp++;
         cmp("R2",  "hblank",  8'(hblank),  8'(e.hb));
         cmp("R3",  "hsync",   8'(hsync),   8'(e.hs));
         cmp("R4",  "vblank",  8'(vblank),  8'(e.vb));
         cmp("R5",  "vsync",   8'(vsync),   8'(e.vs));
         cmp("R10", "disp_en", 8'(disp_en), 8'(e.de));
         cmp("R8",  "status",  status,      e.st);
      end
   end

   // ---------------- enable pattern driver (R7 uses gaps) ----------------
   initial forever begin
      @(negedge clk);
      cyc++;
      case (en_mode)
         1:       char_en = (cyc % 4 != 3);
         2:       char_en = (cyc % 3 == 0);
         default: char_en = 1'b1;
      endcase
   end

   // ---------------- driver tasks ----------------
   task automatic put_byte(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input bit do_start, input bit do_stop);
      @(negedge clk);
      cmd_start = do_start; cmd_stop = do_stop;
      @(negedge clk);
      cmd_start = 1'b0; cmd_stop = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = frames + n;
      while (frames < target) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(190000 * 5);
      n_bad++;
      $display("FAIL watchdog: run did not finish (phase %s)", tag);
      finish_run();
   end

   // ---------------- sequence ----------------
   initial begin
      tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      en_mode = 1;                      // R7: gappy enable through the reset frame
      repeat (300) @(negedge clk);
      // small geometry: A=6, fp=3, hs=2, bp=1+3 -> 15; L=5, vfp=1, vs=2, vbp=2 -> 10
      tag = "R6";
      put_byte(3'd1, 8'h04);
      put_byte(3'd2, 8'h42);
      put_byte(3'd3, 8'h04);
      put_byte(3'd4, 8'h03);
      put_byte(3'd5, 8'h01);
      put_byte(3'd6, 8'h05);
      put_byte(3'd7, 8'h08);
      wait_frames(1);                   // reset frame must stay intact until here
      tag = "R3";
      en_mode = 0;
      wait_frames(3);
      tag = "R9";
      pulse(1'b0, 1'b1);
      repeat (40) @(negedge clk);
      pulse(1'b1, 1'b0);
      repeat (40) @(negedge clk);
      pulse(1'b1, 1'b1);                // stop wins
      repeat (40) @(negedge clk);
      pulse(1'b1, 1'b0);
      tag = "R7";
      en_mode = 2;
      wait_frames(2);
      tag = "R5";                       // zero vertical blanking -> one line
      en_mode = 0;
      put_byte(3'd2, 8'h02);
      put_byte(3'd3, 8'h04);
      put_byte(3'd5, 8'h00);
      put_byte(3'd6, 8'h03);
      put_byte(3'd7, 8'h00);
      wait_frames(3);
      tag = "R4";                       // line field zero -> 1024 lines
      put_byte(3'd1, 8'h00);
      put_byte(3'd2, 8'h21);
      put_byte(3'd3, 8'h00);
      put_byte(3'd4, 8'h00);
      put_byte(3'd6, 8'h00);
      wait_frames(2);
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule